// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

The unit collects seven interrupt sources from neighbouring peripheral logic: two timer time-outs, two control-line edge events for each of two parallel ports, and the end of a serial shift. Each source raises its flag with a one-cycle set pulse and lowers it with a one-cycle clear pulse. The clear pulse comes from the peripheral's own register access, for example any access to the shift data register clears the shift flag. A pending flag interrupts the processor only while its enable bit is set.

The flag register and the enable register share a small register bus with one address bit. Software clears flags by writing ones to them. Software changes the enable mask with a write in which the top bit chooses whether the other ones set or clear enable bits. A summary bit, the top bit of a flag read, reports whether any enabled flag is pending. The active-low request line follows that summary.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every flag and every enable bit is 0, a flag read returns 0x00, an enable read returns 0x80, and irq_no is 1.
- R2: A set pulse on set_i[k] makes flag bit k read 1 from the next cycle on, and it stays 1 until something clears it. Bit map: 6 timer 1 time-out, 5 timer 2 time-out, 4 port B control line 1 edge, 3 port B control line 2 edge, 2 shift complete (eight shifts), 1 port A control line 1 edge, 0 port A control line 2 edge.
- R3: A clear pulse on clr_i[k] makes flag bit k read 0 from the next cycle on. The shift-complete peripheral uses clr_i[2] on any access to its shift register.
- R4: A write to address 0 (flag register) clears each flag k for which wdata_i[k] is 1. Flags with a 0 in wdata_i are unchanged, and wdata_i[7] has no effect.
- R5: When set_i[k] is asserted in the same cycle as a clear of flag k (by clr_i[k] or by a flag write), the flag ends up set.
- R6: A write to address 1 (enable register) with wdata_i[7]=1 sets each enable bit k for which wdata_i[k] is 1. With wdata_i[7]=0 it clears each such bit. Enable bits with a 0 in wdata_i are unchanged.
- R7: A read of address 1 returns 1 in bit 7 and the enable bits in bits 6-0.
- R8: A read of address 0 returns the flags in bits 6-0 and, in bit 7, the summary: 1 exactly when some flag and its matching enable bit are both 1. irq_pending_o carries the same summary.
- R9: irq_no is 0 exactly while the summary is 1.
- R10: A flag can be set while its enable bit is 0. It then produces no request, and it raises the request as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 7 | Per-source flag set pulses |
| clr_i | input | 7 | Per-source flag clear pulses |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 flag, 1 enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_pending_o | output | 1 | Summary: some enabled flag is pending |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is a collision on a single flag, where a set pulse meets a peripheral clear pulse or a software write-clear in the same cycle. The stimulus reaches it in two ways. Directed steps drive a set together with a clear on one bit, and drive a set together with a flag write that has ones on that bit. A long random phase then drives dense, correlated set, clear and write patterns against a behavioural model. A second difficult case is a flag that becomes pending while masked and is enabled later. A directed step covers it.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_EN   = 1'b1;

  typedef enum int unsigned {
    SRC_PA_C2   = 0,
    SRC_PA_C1   = 1,
    SRC_SHIFT   = 2,
    SRC_PB_C2   = 3,
    SRC_PB_C1   = 4,
    SRC_TIMER_2 = 5,
    SRC_TIMER_1 = 6
  } irq_src_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               wr_clr_i,
  input  logic [NUM_SRC-1:0] wr_mask_i,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    logic clr_k;
    assign clr_k = clr_i[k] | (wr_clr_i & wr_mask_i[k]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;  // set has priority
      else if (clr_k)    flag_o[k] <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));  // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((flag_o & ~$past(flag_o)) == '0));  // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && set_i == '0) |=> ((flag_o & $past(clr_i)) == '0));  // R3
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               set_mode_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_o <= '0;
    else if (wr_i) begin
      if (set_mode_i)    en_o <= en_o | mask_i;
      else               en_o <= en_o & ~mask_i;
    end
  end

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));  // R6

  AST_EN_ZEROS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((en_o & ~$past(mask_i)) == ($past(en_o) & ~$past(mask_i))));  // R6
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned NUM_SRC = 7,
  localparam int unsigned DATA_W = NUM_SRC + 1
) (
  input  logic               addr_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               summary_o,
  output logic [DATA_W-1:0]  rdata_o
);
  import irq_flag_pkg::*;

  assign summary_o = |(flag_i & en_i);

  always_comb begin
    if (addr_i == ADDR_EN) rdata_o = {1'b1, en_i};
    else                   rdata_o = {summary_o, flag_i};
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int unsigned SRC_W = NUM_SRC,
  localparam int unsigned DATA_W = SRC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  set_i,
  input  logic [SRC_W-1:0]  clr_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pending_o,
  output logic              irq_no
);
  logic [SRC_W-1:0] flag_q;
  logic [SRC_W-1:0] en_q;
  logic             wr_flag;
  logic             wr_en;
  logic             summary;

  assign wr_flag = wr_i & (addr_i == ADDR_FLAG);
  assign wr_en   = wr_i & (addr_i == ADDR_EN);

  irq_flag_bank #(.NUM_SRC(SRC_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .wr_clr_i  (wr_flag),
    .wr_mask_i (wdata_i[SRC_W-1:0]),
    .flag_o    (flag_q)
  );

  irq_enable_reg #(.NUM_SRC(SRC_W)) u_enable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en),
    .set_mode_i (wdata_i[DATA_W-1]),
    .mask_i     (wdata_i[SRC_W-1:0]),
    .en_o       (en_q)
  );

  irq_read_mux #(.NUM_SRC(SRC_W)) u_read (
    .addr_i    (addr_i),
    .flag_i    (flag_q),
    .en_i      (en_q),
    .summary_o (summary),
    .rdata_o   (rdata_o)
  );

  assign irq_pending_o = summary;
  assign irq_no        = ~summary;

  AST_IRQ_LOW_WHEN_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_o |-> !irq_no);  // R9

  AST_EN_READ_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_EN) |-> rdata_o[DATA_W-1]);  // R7

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> irq_no);  // R10
endmodule

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
  localparam int CLK_HALF = 4;  // 125 MHz

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] set_i = '0;
  logic [6:0] clr_i = '0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_pending_o;
  logic       irq_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_flag = 0;
  int m_en = 0;

  always #CLK_HALF clk_i = ~clk_i;

  irq_flag_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .clr_i(clr_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_pending_o(irq_pending_o), .irq_no(irq_no)
  );

  // behavioural reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag <= 0;
      m_en   <= 0;
    end else begin
      int nf;
      nf = m_flag & ~int'(clr_i);
      if (wr_i && addr_i == 1'b0) nf = nf & ~int'(wdata_i[6:0]);
      nf = nf | int'(set_i);
      m_flag <= nf;
      if (wr_i && addr_i == 1'b1) begin
        if (wdata_i[7]) m_en <= m_en | int'(wdata_i[6:0]);
        else            m_en <= m_en & ~int'(wdata_i[6:0]);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_read(bit a);
    int s;
    s = ((m_flag & m_en) != 0) ? 1 : 0;
    return a ? (128 | m_en) : ((s << 7) | m_flag);
  endfunction

  // compare on every clock, away from the edge
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      int s;
      s = ((m_flag & m_en) != 0) ? 1 : 0;
      chk("R8 read", int'(rdata_o), exp_read(addr_i));
      chk("R8 pending", int'(irq_pending_o), s);
      chk("R9 irq_no", int'(irq_no), 1 - s);
    end
  end

  task automatic drive(logic [6:0] s, logic [6:0] c, logic w, logic a, logic [7:0] d);
    @(negedge clk_i);
    set_i = s; clr_i = c; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    set_i = '0; clr_i = '0; wr_i = 1'b0;
  endtask

  task automatic look(logic a);
    addr_i = a;
    #1;
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    look(1'b0);
    chk("R1 flags after reset", int'(rdata_o), 8'h00);
    chk("R1 irq_no after reset", int'(irq_no), 1);
    look(1'b1);
    chk("R1 R7 enable read after reset", int'(rdata_o), 8'h80);
    rst_ni = 1'b1;

    // R2 R10: timer 1 flag while masked
    drive(7'h40, '0, 1'b0, 1'b0, '0);
    look(1'b0);
    chk("R2 timer1 flag", int'(rdata_o), 8'h40);
    chk("R10 masked no irq", int'(irq_no), 1);
    // R6 R10: enable it
    drive('0, '0, 1'b1, 1'b1, 8'hC0);
    look(1'b0);
    chk("R10 R8 summary after enable", int'(rdata_o), 8'hC0);
    chk("R9 irq low", int'(irq_no), 0);
    // R4: write-one clear
    drive('0, '0, 1'b1, 1'b0, 8'h40);
    look(1'b0);
    chk("R4 write clear", int'(rdata_o), 8'h00);
    chk("R9 irq released", int'(irq_no), 1);
    // R4: partial clear, bit 7 ignored
    drive(7'h07, '0, 1'b0, 1'b0, '0);
    drive('0, '0, 1'b1, 1'b0, 8'h82);
    look(1'b0);
    chk("R4 partial clear", int'(rdata_o), 8'h05);
    // R3: shift flag cleared by peripheral pulse
    drive('0, 7'h04, 1'b0, 1'b0, '0);
    look(1'b0);
    chk("R3 clear pulse", int'(rdata_o), 8'h01);
    // R5: set against clear pulse, then against write clear
    drive(7'h08, 7'h08, 1'b0, 1'b0, '0);
    look(1'b0);
    chk("R5 set beats clr pulse", int'(rdata_o), 8'h09);
    drive(7'h08, '0, 1'b1, 1'b0, 8'h08);
    look(1'b0);
    chk("R5 set beats write clear", int'(rdata_o), 8'h09);
    // R6 R7: set several enables, then clear some
    drive('0, '0, 1'b1, 1'b1, 8'h8F);
    look(1'b1);
    chk("R6 set mode", int'(rdata_o), 8'hCF);
    drive('0, '0, 1'b1, 1'b1, 8'h06);
    look(1'b1);
    chk("R6 R7 clear mode", int'(rdata_o), 8'hC9);
    look(1'b0);
    chk("R8 summary with enabled flags", int'(rdata_o), 8'h89);
    chk("R9 irq low enabled", int'(irq_no), 0);
    drive('0, '0, 1'b1, 1'b1, 8'h7F);
    look(1'b1);
    chk("R6 clear all", int'(rdata_o), 8'h80);
    chk("R10 disabled quiet", int'(irq_no), 1);

    // random phase, checked every clock against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      set_i   = ($urandom_range(0, 3) == 0) ? 7'($urandom) : '0;
      clr_i   = ($urandom_range(0, 2) == 0) ? 7'($urandom) : '0;
      wr_i    = ($urandom_range(0, 3) == 0);
      addr_i  = 1'($urandom);
      wdata_i = 8'($urandom);
    end
    @(negedge clk_i);
    set_i = '0; clr_i = '0; wr_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R1: reset mid-run
    rst_ni = 1'b0;
    #1;
    look(1'b0);
    chk("R1 flags after second reset", int'(rdata_o), 8'h00);
    chk("R1 irq_no after second reset", int'(irq_no), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule